// File: doc/BRIEF.md
# PCI Target Decode Unit for a PCI-to-ISA Bridge

This unit is the target side of a bridge that hands PCI cycles to a slower ISA back end. It samples each PCI address phase, sorts the cycle into a positively decoded range, a subtractive window or no claim at all, and then drives the target control lines DEVSEL#, TRDY# and STOP# for the cycle it takes. A firmware memory range, set by two parameters, is taken with positive decode at medium DEVSEL# timing. A small block of internal register I/O addresses is taken either positively or subtractively, selected by a mode input.

Every other I/O cycle below 64K and every other memory cycle below 16M is taken subtractively. This happens only when no other agent on the bus has raised DEVSEL# by the end of the slow decode window, and the claim is made one clock later. The unit never transfers more than one data phase per cycle. If the master is still holding FRAME# when TRDY# is first driven, STOP# is driven in the same clock so the burst is disconnected.

For each claimed cycle the unit raises a one-clock forward request with the latched address and command, to start the ISA side. It also holds a claim flag, with a marker for subtractive claims, until it lets go of the bus.

Top module: `pci_subdec_target`

## Requirements
- R1: Only the I/O commands (C/BE# = 0010 read, 0011 write) and the memory commands (0110, 0111, 1100, 1110, 1111) can be claimed; any other command, for example configuration read 1010, is never claimed, even at a firmware address.
- R2: A subtractive claim is made only if `other_devsel_n` is sampled high on each of the first four rising edges after the address edge; a low sample on any of them blocks the claim.
- R3: Subtractive decode covers I/O addresses below 0x10000 and memory addresses below 0x1000000; I/O at 0x10000 or above and memory at 0x1000000 or above are not claimed.
- R4: A memory cycle whose address lies in [BIOS_BASE, BIOS_LIMIT] (default 0xE0000 to 0xFFFFF) is claimed positively: DEVSEL# and TRDY# go low on the second rising edge after the address edge, whatever `other_devsel_n` does.
- R5: A subtractive claim drives DEVSEL# and TRDY# low on the fourth rising edge after the address edge, and never earlier.
- R6: If FRAME# is low on the edge that drives TRDY# low, STOP# goes low on that same edge; if FRAME# is high there (single data phase), STOP# stays high for the whole cycle.
- R7: I/O addresses in [REG_BASE, REG_LAST] (default 0xE00 to 0xE1F) are claimed positively at medium timing when `reg_pos_mode` is 1, even if another agent drives DEVSEL#, and subtractively at the fourth edge when it is 0.
- R8: TRDY# goes high on the edge where IRDY# and TRDY# are both sampled low. DEVSEL# and STOP# go high on the first edge, at or after that handshake, that samples FRAME# high; TRDY# is never low while DEVSEL# is high.
- R9: `fwd_req` is high for exactly the one clock that follows the claiming edge. `fwd_addr` and `fwd_cmd` then show the address and command of the address phase. `claim` is 1 from the claim until DEVSEL# is released, and `claim_sub` is 1 during that span only for subtractive claims.
- R10: While `rst_n` is low at a clock edge, DEVSEL#, TRDY# and STOP# are driven high and `claim`, `claim_sub` and `fwd_req` are driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n | input | 1 | FRAME# from the bus |
| irdy_n | input | 1 | IRDY# from the bus |
| ad | input | ADDR_W | Address/data bus, sampled on the address edge |
| cbe_n | input | 4 | C/BE# lines, carrying the command on the address edge |
| other_devsel_n | input | 1 | DEVSEL# as driven by the other agents on the bus |
| reg_pos_mode | input | 1 | 1 = positive, 0 = subtractive decode of the internal register I/O range |
| devsel_n | output | 1 | DEVSEL# driven by this target |
| trdy_n | output | 1 | TRDY# driven by this target |
| stop_n | output | 1 | STOP# driven by this target |
| claim | output | 1 | Cycle currently claimed by this unit |
| claim_sub | output | 1 | Current claim was made subtractively |
| fwd_req | output | 1 | One-clock request to the ISA side |
| fwd_addr | output | ADDR_W | Address of the claimed cycle |
| fwd_cmd | output | 4 | Command of the claimed cycle |

## Verification
The hardest case to reach is another agent's DEVSEL# arriving on the last edge of the slow window, the same edge on which this unit would otherwise claim. To produce it, the bench's master model raises `other_devsel_n` at a chosen edge of 1 to 4 for an otherwise claimable low I/O address, and for positive ranges at edge 1. The bench then checks, edge by edge, that the subtractive claim is withheld while positive claims still occur at edge 2. Bursts and single-phase cycles are run through every claim kind to check the STOP# and release timing.

// File: rtl/pci_subdec_pkg.sv
// Shared definitions for the PCI target decode unit.
// Assumes the standard PCI command encodings on C/BE# during the address phase.
package pci_subdec_pkg;

    // Command codes as they appear on C/BE# (the lines carry them uninverted)
    localparam logic [3:0] CMD_IO_RD   = 4'b0010;
    localparam logic [3:0] CMD_IO_WR   = 4'b0011;
    localparam logic [3:0] CMD_MEM_RD  = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR  = 4'b0111;
    localparam logic [3:0] CMD_MEM_RDM = 4'b1100;
    localparam logic [3:0] CMD_MEM_RDL = 4'b1110;
    localparam logic [3:0] CMD_MEM_WRI = 4'b1111;

    // Edge numbers, counted from the address edge, at which claims are made
    localparam int MED_EDGE = 2;
    localparam int SUB_EDGE = 4;

    // Decode outcome of a latched address phase
    typedef struct packed {
        logic pos;   // positive decode hit
        logic sub;   // eligible for subtractive claim
    } hit_t;

    // Target sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_DATA,
        ST_DISC,
        ST_SKIP
    } tgt_state_e;

endpackage

// File: rtl/subdec_addr_classify.sv
// Address classifier: sorts a latched address/command into positive hit,
// subtractive candidate or nothing. Purely combinational.
// Assumes BIOS and register ranges lie inside their subtractive windows.
module subdec_addr_classify
    import pci_subdec_pkg::*;
#(
    parameter int                ADDR_W        = 32,
    parameter int                IO_SPAN_BITS  = 16,
    parameter int                MEM_SPAN_BITS = 24,
    parameter logic [ADDR_W-1:0] BIOS_BASE     = 'h000E_0000,
    parameter logic [ADDR_W-1:0] BIOS_LIMIT    = 'h000F_FFFF,
    parameter logic [ADDR_W-1:0] REG_BASE      = 'h0000_0E00,
    parameter logic [ADDR_W-1:0] REG_LAST      = 'h0000_0E1F
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        cmd,
    input  logic              reg_pos_mode,
    output hit_t              hit
);

    logic is_io, is_mem, io_win, mem_win, bios_hit, reg_hit;

    // Command class: R1
    always_comb begin
        is_io  = (cmd == CMD_IO_RD) || (cmd == CMD_IO_WR);
        is_mem = (cmd == CMD_MEM_RD)  || (cmd == CMD_MEM_WR) ||
                 (cmd == CMD_MEM_RDM) || (cmd == CMD_MEM_RDL) ||
                 (cmd == CMD_MEM_WRI);
    end

    // Window and range compares: R3, R4, R7
    always_comb begin
        io_win   = (addr[ADDR_W-1:IO_SPAN_BITS]  == '0);
        mem_win  = (addr[ADDR_W-1:MEM_SPAN_BITS] == '0);
        bios_hit = is_mem && (addr >= BIOS_BASE) && (addr <= BIOS_LIMIT);
        reg_hit  = is_io  && (addr >= REG_BASE)  && (addr <= REG_LAST);
    end

    // Final outcome; positive hits exclude subtractive eligibility
    always_comb begin
        hit.pos = bios_hit || (reg_hit && reg_pos_mode);
        hit.sub = !hit.pos && ((is_io && io_win) || (is_mem && mem_win));
    end

endmodule

// File: rtl/subdec_claim_timer.sv
// Decode timer: counts edges after the address edge and remembers whether
// any other agent drove DEVSEL# inside the decode window.
// Assumes start and run are never high together.
module subdec_claim_timer
    import pci_subdec_pkg::*;
#(
    parameter int CNT_W = $clog2(SUB_EDGE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic             other_devsel_n,
    output logic [CNT_W-1:0] cnt,
    output logic             other_any
);

    logic seen_q;

    // Sticky record including the current sample: R2
    assign other_any = seen_q | ~other_devsel_n;

    // Edge counter and sticky other-claim flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            seen_q <= 1'b0;
        end else if (start) begin
            cnt    <= CNT_W'(1);
            seen_q <= 1'b0;
        end else if (run) begin
            if (cnt != CNT_W'(SUB_EDGE))
                cnt <= cnt + CNT_W'(1);
            seen_q <= other_any;
        end
    end

endmodule

// File: rtl/subdec_target_fsm.sv
// Target sequencer: detects address phases, claims at medium or subtractive
// timing, drives DEVSEL#/TRDY#/STOP# and releases them after the last handshake.
// Assumes a master that leaves at least one idle clock between transactions.
module subdec_target_fsm
    import pci_subdec_pkg::*;
#(
    parameter int CNT_W = $clog2(SUB_EDGE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_n,
    input  logic             irdy_n,
    input  logic             other_devsel_n,
    input  hit_t             hit,
    input  logic [CNT_W-1:0] cnt,
    input  logic             other_any,
    output logic             addr_edge,
    output logic             decoding,
    output logic             devsel_n,
    output logic             trdy_n,
    output logic             stop_n,
    output logic             claim,
    output logic             claim_sub,
    output logic             fwd_req
);

    tgt_state_e state;
    logic       frame_q;

    // Address phase: FRAME# newly low while idle
    assign addr_edge = (state == ST_IDLE) && !frame_n && frame_q;
    assign decoding  = (state == ST_DECODE);

    // Main sequencer: claim, data phase, disconnect and release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            frame_q   <= 1'b1;
            devsel_n  <= 1'b1;
            trdy_n    <= 1'b1;
            stop_n    <= 1'b1;
            claim     <= 1'b0;
            claim_sub <= 1'b0;
            fwd_req   <= 1'b0;
        end else begin
            frame_q <= frame_n;
            fwd_req <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (addr_edge)
                        state <= ST_DECODE;
                end
                ST_DECODE: begin
                    if (cnt == CNT_W'(MED_EDGE) && hit.pos) begin
                        // Positive claim at medium timing: R4, R7
                        devsel_n  <= 1'b0;
                        trdy_n    <= 1'b0;
                        stop_n    <= frame_n;
                        claim     <= 1'b1;
                        claim_sub <= 1'b0;
                        fwd_req   <= 1'b1;
                        state     <= ST_DATA;
                    end else if (cnt == CNT_W'(MED_EDGE) && !hit.sub) begin
                        state <= ST_SKIP;
                    end else if (cnt == CNT_W'(SUB_EDGE)) begin
                        if (hit.sub && !other_any) begin
                            // Subtractive claim after the slow window: R2, R5
                            devsel_n  <= 1'b0;
                            trdy_n    <= 1'b0;
                            stop_n    <= frame_n;
                            claim     <= 1'b1;
                            claim_sub <= 1'b1;
                            fwd_req   <= 1'b1;
                            state     <= ST_DATA;
                        end else begin
                            state <= ST_SKIP;
                        end
                    end
                end
                ST_DATA: begin
                    if (!irdy_n && !trdy_n) begin
                        trdy_n <= 1'b1;
                        if (frame_n) begin
                            devsel_n  <= 1'b1;
                            stop_n    <= 1'b1;
                            claim     <= 1'b0;
                            claim_sub <= 1'b0;
                            state     <= ST_IDLE;
                        end else begin
                            state <= ST_DISC;
                        end
                    end else if (!frame_n) begin
                        stop_n <= 1'b0;
                    end
                end
                ST_DISC: begin
                    if (frame_n) begin
                        devsel_n  <= 1'b1;
                        stop_n    <= 1'b1;
                        claim     <= 1'b0;
                        claim_sub <= 1'b0;
                        state     <= ST_IDLE;
                    end
                end
                ST_SKIP: begin
                    if (frame_n && irdy_n)
                        state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_TRDY_UNDER_DEVSEL: assert property (@(posedge clk) disable iff (!rst_n)
        !trdy_n |-> !devsel_n); // R8
    AST_BURST_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(trdy_n) && !$past(frame_n)) |-> !stop_n); // R6
    AST_POS_MEDIUM: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(devsel_n) && !claim_sub) |-> ($past(cnt) == CNT_W'(MED_EDGE))); // R4
    AST_SUB_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(devsel_n) && claim_sub) |-> (($past(cnt) == CNT_W'(SUB_EDGE)) && $past(other_devsel_n))); // R5
    AST_RELEASE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(devsel_n) |-> $past(frame_n)); // R8
    AST_FWD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_req |=> !fwd_req); // R9

endmodule

// File: rtl/pci_subdec_target.sv
// Top of the PCI target decode unit: latches the address phase, classifies
// it, times the claim and drives the target control lines.
// Assumes the bus DEVSEL# of other agents arrives separately on other_devsel_n.
module pci_subdec_target
    import pci_subdec_pkg::*;
#(
    parameter int                ADDR_W        = 32,
    parameter int                IO_SPAN_BITS  = 16,
    parameter int                MEM_SPAN_BITS = 24,
    parameter logic [ADDR_W-1:0] BIOS_BASE     = 'h000E_0000,
    parameter logic [ADDR_W-1:0] BIOS_LIMIT    = 'h000F_FFFF,
    parameter logic [ADDR_W-1:0] REG_BASE      = 'h0000_0E00,
    parameter logic [ADDR_W-1:0] REG_LAST      = 'h0000_0E1F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic [ADDR_W-1:0] ad,
    input  logic [3:0]        cbe_n,
    input  logic              other_devsel_n,
    input  logic              reg_pos_mode,
    output logic              devsel_n,
    output logic              trdy_n,
    output logic              stop_n,
    output logic              claim,
    output logic              claim_sub,
    output logic              fwd_req,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic [3:0]        fwd_cmd
);

    localparam int CNT_W = $clog2(SUB_EDGE + 1);

    logic [ADDR_W-1:0] addr_q;
    logic [3:0]        cmd_q;
    logic              addr_edge, decoding, other_any;
    logic [CNT_W-1:0]  cnt;
    hit_t              hit;

    // Capture address and command on the address edge: R9
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            cmd_q  <= '0;
        end else if (addr_edge) begin
            addr_q <= ad;
            cmd_q  <= cbe_n;
        end
    end

    assign fwd_addr = addr_q;
    assign fwd_cmd  = cmd_q;

    subdec_addr_classify #(
        .ADDR_W       (ADDR_W),
        .IO_SPAN_BITS (IO_SPAN_BITS),
        .MEM_SPAN_BITS(MEM_SPAN_BITS),
        .BIOS_BASE    (BIOS_BASE),
        .BIOS_LIMIT   (BIOS_LIMIT),
        .REG_BASE     (REG_BASE),
        .REG_LAST     (REG_LAST)
    ) u_classify (
        .addr        (addr_q),
        .cmd         (cmd_q),
        .reg_pos_mode(reg_pos_mode),
        .hit         (hit)
    );

    subdec_claim_timer #(.CNT_W(CNT_W)) u_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (addr_edge),
        .run           (decoding),
        .other_devsel_n(other_devsel_n),
        .cnt           (cnt),
        .other_any     (other_any)
    );

    subdec_target_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_n       (frame_n),
        .irdy_n        (irdy_n),
        .other_devsel_n(other_devsel_n),
        .hit           (hit),
        .cnt           (cnt),
        .other_any     (other_any),
        .addr_edge     (addr_edge),
        .decoding      (decoding),
        .devsel_n      (devsel_n),
        .trdy_n        (trdy_n),
        .stop_n        (stop_n),
        .claim         (claim),
        .claim_sub     (claim_sub),
        .fwd_req       (fwd_req)
    );

    AST_SUB_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(claim_sub) |-> ((fwd_cmd[3:1] == 3'b001) ? (fwd_addr[ADDR_W-1:IO_SPAN_BITS] == '0)
                                                       : (fwd_addr[ADDR_W-1:MEM_SPAN_BITS] == '0))); // R3
    AST_CLAIM_TRACKS_DEVSEL: assert property (@(posedge clk) disable iff (!rst_n)
        claim |-> !devsel_n); // R9

endmodule

// File: tb/tb_pci_subdec_target.sv
// Directed bench for the PCI target decode unit; a master model per scenario.
module tb_pci_subdec_target;

    localparam int CLK_PERIOD = 10;
    localparam int K_NONE = 0;
    localparam int K_POS  = 1;
    localparam int K_SUB  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic [31:0] ad = '0;
    logic [3:0]  cbe_n = 4'hF;
    logic        other_devsel_n = 1'b1;
    logic        reg_pos_mode = 1'b0;
    logic        devsel_n, trdy_n, stop_n, claim, claim_sub, fwd_req;
    logic [31:0] fwd_addr;
    logic [3:0]  fwd_cmd;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pci_subdec_target dut (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .ad(ad), .cbe_n(cbe_n), .other_devsel_n(other_devsel_n),
        .reg_pos_mode(reg_pos_mode), .devsel_n(devsel_n), .trdy_n(trdy_n),
        .stop_n(stop_n), .claim(claim), .claim_sub(claim_sub),
        .fwd_req(fwd_req), .fwd_addr(fwd_addr), .fwd_cmd(fwd_cmd)
    );

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    // One transaction by the master model; kind is the expected claim type.
    task automatic txn(input logic [31:0] a, input logic [3:0] c, input bit burst,
                       input int other_at, input int kind, input string tag);
        int first = -1;
        int exp_edge;
        exp_edge = (kind == K_POS) ? 2 : (kind == K_SUB) ? 4 : -1;
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; ad = a; cbe_n = c;
        @(negedge clk);
        irdy_n = 1'b0; frame_n = burst ? 1'b0 : 1'b1; ad = 32'hDDDD_0000; cbe_n = 4'h0;
        if (other_at == 1) other_devsel_n = 1'b0;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            if (devsel_n == 1'b0) begin
                first = i;
                break;
            end
            if (other_at == i + 1) other_devsel_n = 1'b0;
        end
        chk(first == exp_edge, {tag, " claim edge"}, first, exp_edge);
        if (first >= 0) begin
            chk(trdy_n == 1'b0, {tag, " R8 trdy with devsel"}, trdy_n, 0);
            chk(stop_n == !burst, {tag, " R6 stop at first phase"}, stop_n, !burst);
            chk(fwd_req == 1'b1, {tag, " R9 fwd_req"}, fwd_req, 1);
            chk(fwd_addr == a, {tag, " R9 fwd_addr"}, fwd_addr, a);
            chk(fwd_cmd == c, {tag, " R9 fwd_cmd"}, fwd_cmd, c);
            chk(claim == 1'b1, {tag, " R9 claim"}, claim, 1);
            chk(claim_sub == (kind == K_SUB), {tag, " R9 claim_sub"}, claim_sub, kind == K_SUB);
            @(negedge clk);
            chk(fwd_req == 1'b0, {tag, " R9 fwd_req single"}, fwd_req, 0);
            chk(trdy_n == 1'b1, {tag, " R8 trdy release"}, trdy_n, 1);
            if (!burst) begin
                chk(devsel_n == 1'b1, {tag, " R8 devsel release"}, devsel_n, 1);
                chk(claim == 1'b0, {tag, " R9 claim drop"}, claim, 0);
            end else begin
                chk(devsel_n == 1'b0, {tag, " R8 devsel held"}, devsel_n, 0);
                chk(stop_n == 1'b0, {tag, " R6 stop held"}, stop_n, 0);
                frame_n = 1'b1;
                @(negedge clk);
                chk(devsel_n == 1'b1 && stop_n == 1'b1, {tag, " R8 release after frame"},
                    {devsel_n, stop_n}, 2'b11);
                chk(claim == 1'b0, {tag, " R9 claim drop"}, claim, 0);
            end
            chk(stop_n == 1'b1, {tag, " R6 stop idle"}, stop_n, 1);
        end else begin
            frame_n = 1'b1;
            @(negedge clk);
            chk(devsel_n == 1'b1 && claim == 1'b0, {tag, " no late claim"}, devsel_n, 1);
        end
        irdy_n = 1'b1;
        other_devsel_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(devsel_n && trdy_n && stop_n, "R10 reset lines", {devsel_n, trdy_n, stop_n}, 3'b111);
        chk(!claim && !claim_sub && !fwd_req, "R10 reset flags", {claim, claim_sub, fwd_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_bios();
        txn(32'h000E_1234, 4'b0110, 1'b0, 0, K_POS, "R4 bios read");
        txn(32'h000F_FFF0, 4'b1100, 1'b1, 0, K_POS, "R4 R6 bios burst");
        txn(32'h000E_0000, 4'b0111, 1'b0, 1, K_POS, "R4 bios base with other");
        txn(32'h000D_FFFC, 4'b0110, 1'b0, 0, K_SUB, "R4 below bios base");
        txn(32'h0010_0000, 4'b1111, 1'b1, 0, K_SUB, "R4 R6 above bios limit");
    endtask

    task automatic t_windows();
        txn(32'h0012_3456, 4'b0111, 1'b0, 0, K_SUB, "R5 mem low");
        txn(32'h00FF_FFFC, 4'b1110, 1'b1, 0, K_SUB, "R3 R6 mem top of window");
        txn(32'h0100_0000, 4'b0110, 1'b0, 0, K_NONE, "R3 mem 16M");
        txn(32'h0000_03F8, 4'b0010, 1'b0, 0, K_SUB, "R1 R5 io read");
        txn(32'h0000_FFFC, 4'b0011, 1'b1, 0, K_SUB, "R3 io top burst");
        txn(32'h0001_0000, 4'b0011, 1'b0, 0, K_NONE, "R3 io 64K");
    endtask

    task automatic t_commands();
        txn(32'h0000_0000, 4'b1010, 1'b0, 0, K_NONE, "R1 config read");
        txn(32'h000E_8000, 4'b1011, 1'b0, 0, K_NONE, "R1 config write at bios");
        txn(32'h0000_1000, 4'b0000, 1'b0, 0, K_NONE, "R1 int ack");
    endtask

    task automatic t_other();
        txn(32'h0000_03F8, 4'b0010, 1'b0, 2, K_NONE, "R2 other at edge 2");
        txn(32'h0000_03F8, 4'b0010, 1'b0, 3, K_NONE, "R2 other at edge 3");
        txn(32'h0000_2000, 4'b0110, 1'b1, 4, K_NONE, "R2 other at edge 4");
        txn(32'h0000_2000, 4'b0110, 1'b0, 1, K_NONE, "R2 other at edge 1");
    endtask

    task automatic t_regs();
        reg_pos_mode = 1'b1;
        txn(32'h0000_0E10, 4'b0010, 1'b0, 0, K_POS, "R7 reg positive");
        txn(32'h0000_0E1F, 4'b0011, 1'b0, 2, K_POS, "R7 reg positive with other");
        txn(32'h0000_0E20, 4'b0010, 1'b0, 0, K_SUB, "R7 past reg window");
        txn(32'h0000_0E00, 4'b0110, 1'b0, 0, K_SUB, "R7 mem at reg address");
        reg_pos_mode = 1'b0;
        txn(32'h0000_0E10, 4'b0011, 1'b1, 0, K_SUB, "R7 reg subtractive");
        txn(32'h0000_0E00, 4'b0010, 1'b0, 3, K_NONE, "R7 reg subtractive blocked");
    endtask

    initial begin
        t_reset();
        t_bios();
        t_windows();
        t_commands();
        t_other();
        t_regs();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule